// File: doc/BRIEF.md
# NAND Flash Bus Command and Address Capture

This block is the device-side front end of a small-page NAND flash with an 8-bit multiplexed bus. It samples the active-low chip enable and write enable, the command-latch and address-latch strobes and the I/O byte with a system clock that is faster than the bus. Each rising edge of write enable that occurs while chip enable is low produces one bus byte. The block sorts that byte into command, address or data, based on the two latch-enable levels.

A small sequencer follows the command flow for page read, page program and two-phase block erase. It assembles a 26-bit byte address: an 8-bit column and an 18-bit row. Read and program take one column byte and then three row bytes, lowest row byte first. Erase takes only the three row bytes. When a sequence completes, the block emits a one-cycle operation strobe. When a sequence breaks the protocol, it emits a one-cycle error strobe. The captured column and row stay on the outputs for the array logic behind the block. Releasing chip enable discards any unfinished sequence.

Top module: `nand_cmd_capture`

## Requirements
- R1: A bus byte is taken only on a rising edge of `we_n` while `ce_n` is low. Edges while `ce_n` is high have no effect on any output.
- R2: Command 00h followed by four address bytes gives one `read_go` pulse. `col_addr` then equals the first address byte, and `row_addr` equals {b4[1:0], b3, b2}.
- R3: Command 80h followed by four address bytes starts a program. Every later data byte (both latch enables low) gives one `data_stb` pulse with the byte on `data_byte`. Command 10h then gives one `prog_go` pulse, with the address placed as in R2.
- R4: Command 60h followed by three address bytes and then command D0h gives one `erase_go` pulse. `row_addr` equals {b3[1:0], b2, b1} and `col_addr` is zero.
- R5: Command D0h gives `seq_err` and no `erase_go` in two cases: when no erase setup precedes it, and when fewer than three row bytes were given.
- R6: Command 10h gives `seq_err` and no `prog_go` unless a program setup and all four address bytes precede it.
- R7: Any command code other than 00h, 80h, 10h, 60h and D0h is ignored. So is a byte written with both latch enables high. Neither produces a strobe, and a sequence in progress still completes afterwards.
- R8: A rising edge of `ce_n` abandons the sequence in progress without a strobe. A later D0h then reports `seq_err`.
- R9: Some address bytes give `seq_err` and are dropped: one that arrives with no sequence open, one that arrives during the data phase, and a fourth row byte in erase. A start command that interrupts an unfinished sequence gives `seq_err` and begins the new sequence.
- R10: `read_go`, `prog_go`, `erase_go` and `seq_err` are each one cycle wide, and at most one of them is high in any cycle.
- R11: While and after synchronous reset, all strobes are low and both address outputs are zero.
- R12: Bits [7:2] of the last row byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, byte taken on its rising edge |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| io | input | 8 | Multiplexed command/address/data byte |
| read_go | output | 1 | One-cycle page read request |
| prog_go | output | 1 | One-cycle page program request |
| erase_go | output | 1 | One-cycle block erase request |
| seq_err | output | 1 | One-cycle protocol error strobe |
| data_stb | output | 1 | One-cycle data byte strobe during program |
| data_byte | output | 8 | Last accepted program data byte |
| col_addr | output | 8 | Captured column address |
| row_addr | output | 18 | Captured row address |

## Verification
Read and program sequences run with a set of address patterns generated arithmetically, including last row bytes that have their upper bits set. These patterns show whether each byte reaches the right address field and whether truncation works. Erase runs with zero to four row bytes, which separates a short sequence, an exact one and an overlong one. All 256 command codes are written outside any sequence to confirm that only the five defined codes have an effect. Abort, interruption and out-of-order confirms check that the error strobe and the operation strobes never overlap.

// File: rtl/nandcap_pkg.sv
package nandcap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_PG_ADDR,
    ST_PG_DATA,
    ST_ER_ADDR
  } seq_state_t;

  typedef enum logic [1:0] {
    BK_NONE,
    BK_CMD,
    BK_ADDR,
    BK_DATA
  } byte_kind_t;

  localparam logic [7:0] OP_READ        = 8'h00;
  localparam logic [7:0] OP_PROG_SETUP  = 8'h80;
  localparam logic [7:0] OP_PROG_GO     = 8'h10;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;

endpackage

// File: rtl/nandcap_bus_sync.sv
module nandcap_bus_sync #(
  parameter int IO_W   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce_n,
  input  logic            we_n,
  input  logic            cle,
  input  logic            ale,
  input  logic [IO_W-1:0] io,
  output logic            wr_pulse,
  output logic            wr_cle,
  output logic            wr_ale,
  output logic [IO_W-1:0] wr_io,
  output logic            ce_release
);

  localparam int VW = IO_W + 4;
  localparam logic [VW-1:0] BUS_IDLE = {2'b11, {(IO_W + 2){1'b0}}};

  logic [STAGES-1:0][VW-1:0] chain;
  logic [VW-1:0]             now_v;
  logic                      we_q;
  logic                      ce_q;
  logic                      ce_now;
  logic                      we_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= BUS_IDLE;
      we_q <= 1'b1;
      ce_q <= 1'b1;
    end else begin
      chain[0] <= {ce_n, we_n, cle, ale, io};
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      we_q <= we_now;
      ce_q <= ce_now;
    end
  end

  assign now_v      = chain[STAGES-1];
  assign ce_now     = now_v[VW-1];
  assign we_now     = now_v[VW-2];
  assign wr_cle     = now_v[IO_W+1];
  assign wr_ale     = now_v[IO_W];
  assign wr_io      = now_v[IO_W-1:0];
  assign wr_pulse   = we_now & ~we_q & ~ce_now;
  assign ce_release = ce_now & ~ce_q;

  // R1: a detected write edge cannot repeat on the next cycle
  assert_edge_single_R1: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);

endmodule

// File: rtl/nandcap_byte_sort.sv
module nandcap_byte_sort
  import nandcap_pkg::*;
#(
  parameter int IO_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_pulse,
  input  logic            wr_cle,
  input  logic            wr_ale,
  input  logic [IO_W-1:0] wr_io,
  output byte_kind_t      kind,
  output logic [IO_W-1:0] value
);

  byte_kind_t kind_d;

  always_comb begin
    kind_d = BK_NONE;
    if (wr_pulse) begin
      unique case ({wr_cle, wr_ale})
        2'b10:   kind_d = BK_CMD;
        2'b01:   kind_d = BK_ADDR;
        2'b00:   kind_d = BK_DATA;
        default: kind_d = BK_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind  <= BK_NONE;
      value <= '0;
    end else begin
      kind  <= kind_d;
      if (wr_pulse) value <= wr_io;
    end
  end

  // R1: a classified byte only follows an accepted write edge
  assert_kind_from_edge_R1: assert property (@(posedge clk) disable iff (rst)
    (kind != BK_NONE) |-> $past(wr_pulse));

endmodule

// File: rtl/nandcap_seq.sv
module nandcap_seq
  import nandcap_pkg::*;
#(
  parameter int IO_W  = 8,
  parameter int COL_W = 8,
  parameter int ROW_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  byte_kind_t       kind,
  input  logic [IO_W-1:0]  value,
  input  logic             ce_abort,
  output logic             read_go,
  output logic             prog_go,
  output logic             erase_go,
  output logic             seq_err,
  output logic             data_stb,
  output logic [IO_W-1:0]  data_byte,
  output logic [COL_W-1:0] col_addr,
  output logic [ROW_W-1:0] row_addr
);

  localparam int COL_BYTES = (COL_W + IO_W - 1) / IO_W;
  localparam int ROW_BYTES = (ROW_W + IO_W - 1) / IO_W;
  localparam int RW_CYC    = COL_BYTES + ROW_BYTES;
  localparam int ER_CYC    = ROW_BYTES;
  localparam int CNT_W     = $clog2(RW_CYC + 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;

  function automatic logic [ROW_W-1:0] put_row(input logic [ROW_W-1:0] cur,
                                               input logic [IO_W-1:0] b,
                                               input int idx);
    logic [ROW_W-1:0] r;
    r = cur;
    for (int j = 0; j < ROW_W; j++)
      if (j / IO_W == idx) r[j] = b[j % IO_W];
    return r;
  endfunction

  function automatic logic [COL_W-1:0] put_col(input logic [COL_W-1:0] cur,
                                               input logic [IO_W-1:0] b,
                                               input int idx);
    logic [COL_W-1:0] r;
    r = cur;
    for (int j = 0; j < COL_W; j++)
      if (j / IO_W == idx) r[j] = b[j % IO_W];
    return r;
  endfunction

  function automatic logic is_code(input logic [IO_W-1:0] v, input logic [7:0] code);
    return v == IO_W'(code);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      read_go   <= 1'b0;
      prog_go   <= 1'b0;
      erase_go  <= 1'b0;
      seq_err   <= 1'b0;
      data_stb  <= 1'b0;
      data_byte <= '0;
      col_addr  <= '0;
      row_addr  <= '0;
    end else begin
      read_go  <= 1'b0;
      prog_go  <= 1'b0;
      erase_go <= 1'b0;
      seq_err  <= 1'b0;
      data_stb <= 1'b0;
      if (ce_abort) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (kind)
          BK_CMD: begin
            if (is_code(value, OP_READ) || is_code(value, OP_PROG_SETUP) ||
                is_code(value, OP_ERASE_SETUP)) begin
              if (state != ST_IDLE) seq_err <= 1'b1;
              cnt      <= '0;
              col_addr <= '0;
              row_addr <= '0;
              if (is_code(value, OP_READ))            state <= ST_RD_ADDR;
              else if (is_code(value, OP_PROG_SETUP)) state <= ST_PG_ADDR;
              else                                    state <= ST_ER_ADDR;
            end else if (is_code(value, OP_PROG_GO)) begin
              if (state == ST_PG_DATA) prog_go <= 1'b1;
              else                     seq_err <= 1'b1;
              state <= ST_IDLE;
              cnt   <= '0;
            end else if (is_code(value, OP_ERASE_GO)) begin
              if (state == ST_ER_ADDR && cnt == CNT_W'(ER_CYC)) erase_go <= 1'b1;
              else                                              seq_err  <= 1'b1;
              state <= ST_IDLE;
              cnt   <= '0;
            end
          end
          BK_ADDR: begin
            unique case (state)
              ST_RD_ADDR, ST_PG_ADDR: begin
                if (int'(cnt) < COL_BYTES)
                  col_addr <= put_col(col_addr, value, int'(cnt));
                else
                  row_addr <= put_row(row_addr, value, int'(cnt) - COL_BYTES);
                if (cnt == CNT_W'(RW_CYC - 1)) begin
                  cnt <= '0;
                  if (state == ST_RD_ADDR) begin
                    read_go <= 1'b1;
                    state   <= ST_IDLE;
                  end else begin
                    state <= ST_PG_DATA;
                  end
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
              ST_ER_ADDR: begin
                if (int'(cnt) < ER_CYC) begin
                  row_addr <= put_row(row_addr, value, int'(cnt));
                  cnt      <= cnt + 1'b1;
                end else begin
                  seq_err <= 1'b1;
                end
              end
              default: seq_err <= 1'b1;
            endcase
          end
          BK_DATA: begin
            if (state == ST_PG_DATA) begin
              data_stb  <= 1'b1;
              data_byte <= value;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: result strobes never overlap
  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({read_go, prog_go, erase_go, seq_err}));

  // R10: a read request lasts one cycle
  assert_read_single_R10: assert property (@(posedge clk) disable iff (rst)
    read_go |=> !read_go);

  // R3: program request follows a confirm command
  assert_prog_after_confirm_R3: assert property (@(posedge clk) disable iff (rst)
    prog_go |-> $past(kind == BK_CMD && is_code(value, OP_PROG_GO)));

  // R4: erase request follows an erase confirm command
  assert_erase_after_confirm_R4: assert property (@(posedge clk) disable iff (rst)
    erase_go |-> $past(kind == BK_CMD && is_code(value, OP_ERASE_GO)));

  // R9: the address byte counter stays within the longest sequence
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= RW_CYC);

  // R8: chip enable release leaves the sequencer idle
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
    ce_abort |=> (state == ST_IDLE && cnt == '0));

endmodule

// File: rtl/nand_cmd_capture.sv
module nand_cmd_capture
  import nandcap_pkg::*;
#(
  parameter int IO_W        = 8,
  parameter int COL_W       = 8,
  parameter int ROW_W       = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             cle,
  input  logic             ale,
  input  logic [IO_W-1:0]  io,
  output logic             read_go,
  output logic             prog_go,
  output logic             erase_go,
  output logic             seq_err,
  output logic             data_stb,
  output logic [IO_W-1:0]  data_byte,
  output logic [COL_W-1:0] col_addr,
  output logic [ROW_W-1:0] row_addr
);

  logic            wr_pulse;
  logic            wr_cle;
  logic            wr_ale;
  logic [IO_W-1:0] wr_io;
  logic            ce_release;
  byte_kind_t      kind;
  logic [IO_W-1:0] value;

  nandcap_bus_sync #(.IO_W(IO_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale), .io(io),
    .wr_pulse(wr_pulse), .wr_cle(wr_cle), .wr_ale(wr_ale), .wr_io(wr_io),
    .ce_release(ce_release)
  );

  nandcap_byte_sort #(.IO_W(IO_W)) u_sort (
    .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .wr_cle(wr_cle), .wr_ale(wr_ale),
    .wr_io(wr_io), .kind(kind), .value(value)
  );

  nandcap_seq #(.IO_W(IO_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_seq (
    .clk(clk), .rst(rst), .kind(kind), .value(value), .ce_abort(ce_release),
    .read_go(read_go), .prog_go(prog_go), .erase_go(erase_go), .seq_err(seq_err),
    .data_stb(data_stb), .data_byte(data_byte), .col_addr(col_addr), .row_addr(row_addr)
  );

endmodule

// File: tb/nand_cmd_capture_bench.sv
module nand_cmd_capture_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1;
  logic        we_n = 1'b1;
  logic        cle = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  io = 8'h00;
  logic        read_go, prog_go, erase_go, seq_err, data_stb;
  logic [7:0]  data_byte, col_addr;
  logic [17:0] row_addr;

  int n_checks = 0;
  int n_fail = 0;
  int n_rd = 0, n_pg = 0, n_er = 0, n_err = 0, n_dat = 0;
  int n_multi = 0, n_wide = 0;
  logic [7:0]  cap_col;
  logic [17:0] cap_row;
  logic [7:0]  cap_dat [16];
  logic        p_rd = 0, p_pg = 0, p_er = 0, p_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_cmd_capture u_nand_cmd_capture (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale), .io(io),
    .read_go(read_go), .prog_go(prog_go), .erase_go(erase_go), .seq_err(seq_err),
    .data_stb(data_stb), .data_byte(data_byte), .col_addr(col_addr), .row_addr(row_addr)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (read_go)  begin n_rd++; cap_col = col_addr; cap_row = row_addr; end
      if (prog_go)  begin n_pg++; cap_col = col_addr; cap_row = row_addr; end
      if (erase_go) begin n_er++; cap_col = col_addr; cap_row = row_addr; end
      if (seq_err)  n_err++;
      if (data_stb) begin cap_dat[n_dat % 16] = data_byte; n_dat++; end
      if (int'(read_go) + int'(prog_go) + int'(erase_go) + int'(seq_err) > 1) n_multi++;
      if ((read_go && p_rd) || (prog_go && p_pg) || (erase_go && p_er) || (seq_err && p_err))
        n_wide++;
      p_rd = read_go; p_pg = prog_go; p_er = erase_go; p_err = seq_err;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic c_n, input logic l_cle, input logic l_ale, input logic [7:0] v);
    ce_n = c_n; cle = l_cle; ale = l_ale; io = v;
    repeat (2) @(negedge clk);
    we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] v); bus_wr(1'b0, 1'b1, 1'b0, v); endtask
  task automatic adr(input logic [7:0] v); bus_wr(1'b0, 1'b0, 1'b1, v); endtask
  task automatic dat(input logic [7:0] v); bus_wr(1'b0, 1'b0, 1'b0, v); endtask
  task automatic settle(); repeat (8) @(negedge clk); endtask
  task automatic ce_off(); ce_n = 1'b1; repeat (6) @(negedge clk); endtask

  function automatic logic [17:0] mkrow(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    return {c[1:0], b, a};
  endfunction

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int b_rd, b_pg, b_er, b_err, b_dat;
    logic [7:0] c0, r1, r2, r3;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk({read_go, prog_go, erase_go, seq_err} == 4'b0, "R11 strobes", {read_go, prog_go, erase_go, seq_err}, 0);
    chk(col_addr == 0 && row_addr == 0, "R11 address", int'(row_addr), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({read_go, prog_go, erase_go, seq_err} == 4'b0, "R11 after release", {read_go, prog_go, erase_go, seq_err}, 0);

    // R1: writes with chip enable high are ignored
    b_rd = n_rd; b_err = n_err;
    bus_wr(1'b1, 1'b1, 1'b0, 8'h00);
    for (int k = 0; k < 4; k++) bus_wr(1'b1, 1'b0, 1'b1, 8'(k * 9 + 1));
    bus_wr(1'b1, 1'b0, 1'b1, 8'h33);
    settle();
    chk(n_rd == b_rd, "R1 no read with ce high", n_rd - b_rd, 0);
    chk(n_err == b_err, "R1 no error with ce high", n_err - b_err, 0);

    // R2 / R12: read address sweep
    for (int p = 0; p < 8; p++) begin
      c0 = 8'(p * 37 + 5); r1 = 8'(p * 53 + 11); r2 = 8'(p * 29 + 200); r3 = 8'(p * 71 + 3) | 8'hFC;
      b_rd = n_rd; b_err = n_err;
      cmd(8'h00); adr(c0); adr(r1); adr(r2); adr(r3);
      settle();
      chk(n_rd == b_rd + 1, "R2 read pulse", n_rd - b_rd, 1);
      chk(cap_col == c0, "R2 column", int'(cap_col), int'(c0));
      chk(cap_row == mkrow(r1, r2, r3), "R12 row with upper bits", int'(cap_row), int'(mkrow(r1, r2, r3)));
      chk(n_err == b_err, "R2 no error", n_err - b_err, 0);
    end

    // R3: program with 1..4 data bytes
    for (int p = 0; p < 4; p++) begin
      c0 = 8'(p * 61 + 7); r1 = 8'(p * 17 + 90); r2 = 8'(p * 45 + 3); r3 = 8'(p + 1);
      b_pg = n_pg; b_dat = n_dat; b_err = n_err;
      cmd(8'h80); adr(c0); adr(r1); adr(r2); adr(r3);
      for (int k = 0; k <= p; k++) dat(8'(p * 16 + k + 1));
      settle();
      chk(n_dat == b_dat + p + 1, "R3 data count", n_dat - b_dat, p + 1);
      chk(cap_dat[(n_dat - 1) % 16] == 8'(p * 17 + 1), "R3 last data byte",
          int'(cap_dat[(n_dat - 1) % 16]), p * 17 + 1);
      chk(n_pg == b_pg, "R3 no program before confirm", n_pg - b_pg, 0);
      cmd(8'h10);
      settle();
      chk(n_pg == b_pg + 1, "R3 program pulse", n_pg - b_pg, 1);
      chk(cap_col == c0 && cap_row == mkrow(r1, r2, r3), "R3 program address",
          int'(cap_row), int'(mkrow(r1, r2, r3)));
      chk(n_err == b_err, "R3 no error", n_err - b_err, 0);
    end

    // R4 / R5 / R9: erase with 0..4 row bytes
    for (int n = 0; n <= 4; n++) begin
      b_er = n_er; b_err = n_err;
      cmd(8'h60);
      for (int k = 0; k < n; k++) adr(8'(n * 40 + k * 13 + 6));
      cmd(8'hD0);
      settle();
      if (n < 3) begin
        chk(n_er == b_er, "R5 short erase blocked", n_er - b_er, 0);
        chk(n_err == b_err + 1, "R5 short erase error", n_err - b_err, 1);
      end else begin
        chk(n_er == b_er + 1, "R4 erase pulse", n_er - b_er, 1);
        chk(cap_row == mkrow(8'(n * 40 + 6), 8'(n * 40 + 19), 8'(n * 40 + 32)), "R4 erase row",
            int'(cap_row), int'(mkrow(8'(n * 40 + 6), 8'(n * 40 + 19), 8'(n * 40 + 32))));
        chk(cap_col == 0, "R4 erase column zero", int'(cap_col), 0);
        chk(n_err == b_err + (n - 3), "R9 extra row byte error", n_err - b_err, n - 3);
      end
    end

    // R5: confirm without setup
    b_er = n_er; b_err = n_err;
    cmd(8'hD0); settle();
    chk(n_er == b_er && n_err == b_err + 1, "R5 confirm without setup", n_err - b_err, 1);

    // R6: program confirm with short address and in idle
    b_pg = n_pg; b_err = n_err;
    cmd(8'h80); adr(8'h12); adr(8'h34); cmd(8'h10); settle();
    chk(n_pg == b_pg && n_err == b_err + 1, "R6 short program", n_err - b_err, 1);
    cmd(8'h10); settle();
    chk(n_pg == b_pg && n_err == b_err + 2, "R6 confirm in idle", n_err - b_err, 2);

    // R7: every other code is ignored while idle
    b_rd = n_rd; b_pg = n_pg; b_er = n_er; b_err = n_err;
    for (int c = 0; c < 256; c++) begin
      if (c != 8'h00 && c != 8'h80 && c != 8'h10 && c != 8'h60 && c != 8'hD0) cmd(8'(c));
    end
    settle();
    chk(n_rd + n_pg + n_er + n_err == b_rd + b_pg + b_er + b_err, "R7 unknown codes",
        n_rd + n_pg + n_er + n_err - b_rd - b_pg - b_er - b_err, 0);
    // R7: unknown code and both latches high inside an erase
    b_er = n_er; b_err = n_err;
    cmd(8'h60); adr(8'hA1); cmd(8'hFF); bus_wr(1'b0, 1'b1, 1'b1, 8'h77);
    adr(8'hB2); adr(8'h03); cmd(8'hD0); settle();
    chk(n_er == b_er + 1 && n_err == b_err, "R7 erase survives ignored bytes", n_er - b_er, 1);
    chk(cap_row == mkrow(8'hA1, 8'hB2, 8'h03), "R7 erase row", int'(cap_row), int'(mkrow(8'hA1, 8'hB2, 8'h03)));

    // R8: chip enable release aborts
    b_er = n_er; b_err = n_err;
    cmd(8'h60); adr(8'h01); adr(8'h02); adr(8'h03); ce_off();
    chk(n_err == b_err, "R8 abort silent", n_err - b_err, 0);
    cmd(8'hD0); settle();
    chk(n_er == b_er && n_err == b_err + 1, "R8 confirm after abort", n_err - b_err, 1);

    // R9: address byte in idle and interrupted sequence
    b_err = n_err;
    adr(8'h55); settle();
    chk(n_err == b_err + 1, "R9 address in idle", n_err - b_err, 1);
    b_rd = n_rd; b_err = n_err;
    cmd(8'h00); adr(8'h10); cmd(8'h00); adr(8'h20); adr(8'h21); adr(8'h22); adr(8'h23); settle();
    chk(n_err == b_err + 1 && n_rd == b_rd + 1, "R9 interrupted read", n_err - b_err, 1);
    chk(cap_col == 8'h20, "R9 restarted column", int'(cap_col), 8'h20);

    // R10: strobe width and exclusivity over the whole run
    chk(n_multi == 0, "R10 overlapping strobes", n_multi, 0);
    chk(n_wide == 0, "R10 wide strobes", n_wide, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule